// File: doc/BRIEF.md
# Sharer-Vector Coherence Directory

This block is the directory controller in front of a shared cache level. For every block it tracks, it keeps a coherence state, a copy of the block data, a flag that says whether the data has been fetched yet, and a sharer vector with one bit per core. Private caches send it read, write, instruction-read and write-back requests. The directory answers from its own copy when that copy is current. When one core owns the block, it forwards the request to that core. When the block has never been fetched, it asks lower memory for it first. Before it grants write permission to a block that other cores share, it sends one multicast invalidation addressed only to those other sharers and waits until every one of them has acknowledged.

The controller works on one transaction at a time. Once a request is accepted, the request port stays closed until the response has been taken. This keeps the block being worked on locked, and later requests wait at the port.

The request, response, forward, invalidation and memory-request ports use valid/ready handshakes. Each of these outputs, once valid, keeps its payload steady until ready is seen high on a rising clock edge. A requester may hold `req_valid` for as long as it likes. Three inputs are single-cycle pulses that the directory always accepts, so they have no ready: the owner's data reply, invalidation acknowledgements and the memory reply.

Top module: `sharer_directory`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `fwd_valid`, `inv_valid` and `mem_req_valid` are 0. Every entry starts uncached, with no sharers and no data fetched.
- R2: A read, write or instruction request to a block whose data has never been fetched raises `mem_req_valid` with `mem_req_blk` equal to the block. The data later returned on `mem_rsp_data` is stored and delivered to the requester. Any later grant from the directory's own copy issues no memory request.
- R3: A read (`req_type`=0) to an uncached block returns `rsp_kind`=1 (exclusive) and records the requester as the only owner.
- R4: An instruction read (`req_type`=2) to an uncached block returns `rsp_kind`=0 (shared) and makes the requester the single sharer.
- R5: A read or instruction read to a shared block returns `rsp_kind`=0 with the stored data, adds the requester to the sharers, and sends no forward, invalidation or memory request.
- R6: A write (`req_type`=1) to a shared block with other sharers sends exactly one invalidation. Its `inv_mask` equals the sharer vector minus the requester. The exclusive response (`rsp_kind`=1) appears only after an `ack_valid` pulse has arrived from every core in that mask.
- R7: A write to an uncached block, or to a shared block whose only sharer is the requester, is granted exclusive at once with no invalidation.
- R8: A read, instruction read or write to a block owned by a different core sends a forward to the owner. The forward carries `fwd_core`=owner, `fwd_req_core`=requester, and `fwd_kind`=0 for reads or 1 for writes. The directory stores the data the owner returns and passes it to the requester: shared for reads, with owner and requester both left as sharers, or exclusive for writes, with ownership moved to the requester.
- R9: A write-back (`req_type`=3) from the recorded owner stores `req_data` and returns the entry to uncached with no sharers. A write-back from any other core leaves data and state unchanged. Both cases are answered with `rsp_kind`=2 and `rsp_data`=0.
- R10: After a request is accepted, `req_ready` stays 0 until the response handshake completes.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_kind` and `rsp_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Directory idle and accepting a request |
| req_type | input | 2 | 0 read, 1 write, 2 instruction read, 3 write-back |
| req_core | input | log2(NUM_CORES) | Requesting core |
| req_blk | input | log2(NUM_ENTRIES) | Block index |
| req_data | input | DATA_W | Write-back data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_kind | output | 2 | 0 shared grant, 1 exclusive grant, 2 write-back acknowledge |
| rsp_core | output | log2(NUM_CORES) | Destination core |
| rsp_blk | output | log2(NUM_ENTRIES) | Block index |
| rsp_data | output | DATA_W | Block data, 0 for write-back acknowledge |
| fwd_valid | output | 1 | Forward to owner offered |
| fwd_ready | input | 1 | Forward taken |
| fwd_kind | output | 1 | 0 for a read, 1 for a write |
| fwd_core | output | log2(NUM_CORES) | Owning core addressed |
| fwd_req_core | output | log2(NUM_CORES) | Core that made the request |
| fwd_blk | output | log2(NUM_ENTRIES) | Block index |
| own_valid | input | 1 | Owner returns its data (pulse) |
| own_data | input | DATA_W | Owner data |
| inv_valid | output | 1 | Multicast invalidation offered |
| inv_ready | input | 1 | Invalidation taken |
| inv_mask | output | NUM_CORES | Cores to invalidate |
| inv_blk | output | log2(NUM_ENTRIES) | Block index |
| ack_valid | input | 1 | Invalidation acknowledgement (pulse) |
| ack_core | input | log2(NUM_CORES) | Acknowledging core |
| mem_req_valid | output | 1 | Fetch request to lower memory |
| mem_req_ready | input | 1 | Fetch request taken |
| mem_req_blk | output | log2(NUM_ENTRIES) | Block to fetch |
| mem_rsp_valid | input | 1 | Memory data returned (pulse) |
| mem_rsp_data | input | DATA_W | Memory data |

## Verification
The bench goes after the write to a shared block. It acknowledges the invalidation one core per cycle after a delay, so a directory that granted early, or that put the requester or a non-sharer in the mask, would answer before the last acknowledgement or show the wrong mask. It also checks write-backs from the owner and from a core that is not the owner: a directory that accepted a stale write-back would return the wrong data on the next grant. Forwarding is checked in both directions: a directory that answered from its stale copy would skip the forward and deliver old data, and one that tracked the owner wrongly would address the wrong core later. It stalls every response for two cycles and checks that the data does not move, and it counts memory fetches so that a fetch repeated on a block already fetched is caught.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
  typedef enum logic [1:0] {
    ENT_UNC = 2'd0,
    ENT_SHR = 2'd1,
    ENT_EXC = 2'd2
  } ent_state_e;

  typedef enum logic [1:0] {
    RQ_RD = 2'd0,
    RQ_WR = 2'd1,
    RQ_IF = 2'd2,
    RQ_WB = 2'd3
  } req_kind_e;

  localparam logic [1:0] RS_SHR = 2'd0;
  localparam logic [1:0] RS_EXC = 2'd1;
  localparam logic [1:0] RS_WBA = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_MREQ, S_MWAIT, S_FWD, S_FWAIT, S_INV, S_AWAIT, S_RESP
  } dir_fsm_e;
endpackage

// File: rtl/dir_table.sv
module dir_table
  import dirc_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_ENTRIES = 8,
  parameter int DATA_W      = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [$clog2(NUM_ENTRIES)-1:0] blk,
  output ent_state_e                     rd_state,
  output logic [NUM_CORES-1:0]           rd_sharers,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           rd_present,
  input  logic                           wr_meta_en,
  input  ent_state_e                     wr_state,
  input  logic [NUM_CORES-1:0]           wr_sharers,
  input  logic                           wr_data_en,
  input  logic [DATA_W-1:0]              wr_data
);
  ent_state_e             st_q   [NUM_ENTRIES];
  logic [NUM_CORES-1:0]   sh_q   [NUM_ENTRIES];
  logic [DATA_W-1:0]      dat_q  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] pres_q;

  assign rd_state   = st_q[blk];
  assign rd_sharers = sh_q[blk];
  assign rd_data    = dat_q[blk];
  assign rd_present = pres_q[blk];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        st_q[i] <= ENT_UNC;
        sh_q[i] <= '0;
      end
      pres_q <= '0;
    end else begin
      if (wr_meta_en) begin
        st_q[blk] <= wr_state;
        sh_q[blk] <= wr_sharers;
      end
      if (wr_data_en) pres_q[blk] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_data_en) dat_q[blk] <= wr_data;
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent_chk
    // R3
    owner_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] == ENT_EXC |-> $countones(sh_q[g]) == 1);
    // R9
    uncached_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] == ENT_UNC |-> sh_q[g] == '0);
  end
endmodule

// File: rtl/ack_tracker.sv
module ack_tracker #(
  parameter int NUM_CORES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [NUM_CORES-1:0]         load_mask,
  input  logic                         ack_valid,
  input  logic [$clog2(NUM_CORES)-1:0] ack_core,
  output logic [NUM_CORES-1:0]         pending,
  output logic                         all_done
);
  logic [NUM_CORES-1:0] pend_q;
  logic [NUM_CORES-1:0] ack_bit;

  assign ack_bit  = ack_valid ? ({{(NUM_CORES-1){1'b0}}, 1'b1} << ack_core) : '0;
  assign pending  = pend_q;
  assign all_done = (pend_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    pend_q <= '0;
    else if (load) pend_q <= load_mask;
    else           pend_q <= pend_q & ~ack_bit;
  end

  // R6
  ack_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> pend_q[ack_core]);
endmodule

// File: rtl/sharer_directory.sv
module sharer_directory
  import dirc_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_ENTRIES = 8,
  parameter int DATA_W      = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [1:0]                     req_type,
  input  logic [$clog2(NUM_CORES)-1:0]   req_core,
  input  logic [$clog2(NUM_ENTRIES)-1:0] req_blk,
  input  logic [DATA_W-1:0]              req_data,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [1:0]                     rsp_kind,
  output logic [$clog2(NUM_CORES)-1:0]   rsp_core,
  output logic [$clog2(NUM_ENTRIES)-1:0] rsp_blk,
  output logic [DATA_W-1:0]              rsp_data,
  output logic                           fwd_valid,
  input  logic                           fwd_ready,
  output logic                           fwd_kind,
  output logic [$clog2(NUM_CORES)-1:0]   fwd_core,
  output logic [$clog2(NUM_CORES)-1:0]   fwd_req_core,
  output logic [$clog2(NUM_ENTRIES)-1:0] fwd_blk,
  input  logic                           own_valid,
  input  logic [DATA_W-1:0]              own_data,
  output logic                           inv_valid,
  input  logic                           inv_ready,
  output logic [NUM_CORES-1:0]           inv_mask,
  output logic [$clog2(NUM_ENTRIES)-1:0] inv_blk,
  input  logic                           ack_valid,
  input  logic [$clog2(NUM_CORES)-1:0]   ack_core,
  output logic                           mem_req_valid,
  input  logic                           mem_req_ready,
  output logic [$clog2(NUM_ENTRIES)-1:0] mem_req_blk,
  input  logic                           mem_rsp_valid,
  input  logic [DATA_W-1:0]              mem_rsp_data
);
  localparam int CORE_W = $clog2(NUM_CORES);
  localparam int BLK_W  = $clog2(NUM_ENTRIES);

  dir_fsm_e             state, nxt;
  req_kind_e            cur_kind;
  logic [CORE_W-1:0]    cur_core;
  logic [BLK_W-1:0]     cur_blk;
  logic [DATA_W-1:0]    cur_data;
  logic [NUM_CORES-1:0] req_bit, others;
  logic [CORE_W-1:0]    owner_idx;

  ent_state_e           rd_state, wr_state;
  logic [NUM_CORES-1:0] rd_sharers, wr_sharers;
  logic [DATA_W-1:0]    rd_data, wr_data;
  logic                 rd_present, wr_meta_en, wr_data_en;

  logic                 set_rsp, set_fwd, ack_load, acks_done;
  logic [1:0]           rsp_kind_d, rsp_kind_q;
  logic [DATA_W-1:0]    rsp_data_d, rsp_data_q;
  logic                 fwd_kind_d, fwd_kind_q;
  logic [CORE_W-1:0]    fwd_core_q;
  logic [NUM_CORES-1:0] inv_mask_q, acks_pending;

  dir_table #(.NUM_CORES(NUM_CORES), .NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W)) u_table (
    .clk(clk), .rst_n(rst_n), .blk(cur_blk),
    .rd_state(rd_state), .rd_sharers(rd_sharers), .rd_data(rd_data), .rd_present(rd_present),
    .wr_meta_en(wr_meta_en), .wr_state(wr_state), .wr_sharers(wr_sharers),
    .wr_data_en(wr_data_en), .wr_data(wr_data)
  );

  ack_tracker #(.NUM_CORES(NUM_CORES)) u_acks (
    .clk(clk), .rst_n(rst_n), .load(ack_load), .load_mask(others),
    .ack_valid(ack_valid), .ack_core(ack_core),
    .pending(acks_pending), .all_done(acks_done)
  );

  assign req_bit = {{(NUM_CORES-1){1'b0}}, 1'b1} << cur_core;
  assign others  = rd_sharers & ~req_bit;

  always_comb begin
    owner_idx = '0;
    for (int k = NUM_CORES - 1; k >= 0; k--)
      if (rd_sharers[k]) owner_idx = CORE_W'(k);
  end

  always_comb begin
    nxt        = state;
    wr_meta_en = 1'b0;
    wr_state   = ENT_UNC;
    wr_sharers = '0;
    wr_data_en = 1'b0;
    wr_data    = rd_data;
    set_rsp    = 1'b0;
    rsp_kind_d = RS_SHR;
    rsp_data_d = rd_data;
    set_fwd    = 1'b0;
    fwd_kind_d = (cur_kind == RQ_WR);
    ack_load   = 1'b0;
    unique case (state)
      S_IDLE: if (req_valid) nxt = S_LOOK;
      S_LOOK: begin
        if (cur_kind == RQ_WB) begin
          if (rd_state == ENT_EXC && rd_sharers == req_bit) begin
            wr_meta_en = 1'b1;
            wr_data_en = 1'b1;
            wr_data    = cur_data;
          end
          set_rsp    = 1'b1;
          rsp_kind_d = RS_WBA;
          rsp_data_d = '0;
        end else if (!rd_present) begin
          nxt = S_MREQ;
        end else begin
          unique case (rd_state)
            ENT_SHR: begin
              if (cur_kind == RQ_WR) begin
                if (others != '0) begin
                  ack_load = 1'b1;
                  nxt      = S_INV;
                end else begin
                  wr_meta_en = 1'b1;
                  wr_state   = ENT_EXC;
                  wr_sharers = req_bit;
                  set_rsp    = 1'b1;
                  rsp_kind_d = RS_EXC;
                end
              end else begin
                wr_meta_en = 1'b1;
                wr_state   = ENT_SHR;
                wr_sharers = rd_sharers | req_bit;
                set_rsp    = 1'b1;
              end
            end
            ENT_EXC: begin
              if (rd_sharers == req_bit) begin
                set_rsp    = 1'b1;
                rsp_kind_d = RS_EXC;
              end else begin
                set_fwd = 1'b1;
                nxt     = S_FWD;
              end
            end
            default: begin
              wr_meta_en = 1'b1;
              wr_state   = (cur_kind == RQ_IF) ? ENT_SHR : ENT_EXC;
              wr_sharers = req_bit;
              set_rsp    = 1'b1;
              rsp_kind_d = (cur_kind == RQ_IF) ? RS_SHR : RS_EXC;
            end
          endcase
        end
      end
      S_MREQ:  if (mem_req_ready) nxt = S_MWAIT;
      S_MWAIT: begin
        if (mem_rsp_valid) begin
          wr_data_en = 1'b1;
          wr_data    = mem_rsp_data;
          nxt        = S_LOOK;
        end
      end
      S_FWD:   if (fwd_ready) nxt = S_FWAIT;
      S_FWAIT: begin
        if (own_valid) begin
          wr_data_en = 1'b1;
          wr_data    = own_data;
          wr_meta_en = 1'b1;
          set_rsp    = 1'b1;
          rsp_data_d = own_data;
          if (cur_kind == RQ_WR) begin
            wr_state   = ENT_EXC;
            wr_sharers = req_bit;
            rsp_kind_d = RS_EXC;
          end else begin
            wr_state   = ENT_SHR;
            wr_sharers = rd_sharers | req_bit;
          end
        end
      end
      S_INV:   if (inv_ready) nxt = S_AWAIT;
      S_AWAIT: begin
        if (acks_done) begin
          wr_meta_en = 1'b1;
          wr_state   = ENT_EXC;
          wr_sharers = req_bit;
          set_rsp    = 1'b1;
          rsp_kind_d = RS_EXC;
        end
      end
      S_RESP:  if (rsp_ready) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (set_rsp) nxt = S_RESP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_kind   <= RQ_RD;
      cur_core   <= '0;
      cur_blk    <= '0;
      cur_data   <= '0;
      rsp_kind_q <= RS_SHR;
      rsp_data_q <= '0;
      fwd_kind_q <= 1'b0;
      fwd_core_q <= '0;
      inv_mask_q <= '0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && req_valid) begin
        cur_kind <= req_kind_e'(req_type);
        cur_core <= req_core;
        cur_blk  <= req_blk;
        cur_data <= req_data;
      end
      if (set_rsp) begin
        rsp_kind_q <= rsp_kind_d;
        rsp_data_q <= rsp_data_d;
      end
      if (set_fwd) begin
        fwd_kind_q <= fwd_kind_d;
        fwd_core_q <= owner_idx;
      end
      if (ack_load) inv_mask_q <= others;
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign rsp_valid     = (state == S_RESP);
  assign rsp_kind      = rsp_kind_q;
  assign rsp_core      = cur_core;
  assign rsp_blk       = cur_blk;
  assign rsp_data      = rsp_data_q;
  assign fwd_valid     = (state == S_FWD);
  assign fwd_kind      = fwd_kind_q;
  assign fwd_core      = fwd_core_q;
  assign fwd_req_core  = cur_core;
  assign fwd_blk       = cur_blk;
  assign inv_valid     = (state == S_INV);
  assign inv_mask      = inv_mask_q;
  assign inv_blk       = cur_blk;
  assign mem_req_valid = (state == S_MREQ);
  assign mem_req_blk   = cur_blk;

  // R10
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_kind));
  // R6
  grant_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == RS_EXC |-> acks_pending == '0);
  // R6
  inv_targets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_mask & req_bit) == '0 && inv_mask != '0);
  // R8
  fwd_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> fwd_core != cur_core);
endmodule

// File: tb/test_sharer_directory.sv
module test_sharer_directory;
  localparam int NC = 4;
  localparam int NE = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 0, rsp_ready = 0, fwd_ready = 1, inv_ready = 1, mem_req_ready = 1;
  logic [1:0]    req_type = 0;
  logic [1:0]    req_core = 0;
  logic [2:0]    req_blk = 0;
  logic [DW-1:0] req_data = 0;
  logic          own_valid = 0, ack_valid = 0, mem_rsp_valid = 0;
  logic [DW-1:0] own_data = 0, mem_rsp_data = 0;
  logic [1:0]    ack_core = 0;
  logic          req_ready, rsp_valid, fwd_valid, fwd_kind, inv_valid, mem_req_valid;
  logic [1:0]    rsp_kind, rsp_core, fwd_core, fwd_req_core;
  logic [2:0]    rsp_blk, fwd_blk, inv_blk, mem_req_blk;
  logic [DW-1:0] rsp_data;
  logic [NC-1:0] inv_mask;

  sharer_directory #(.NUM_CORES(NC), .NUM_ENTRIES(NE), .DATA_W(DW)) i_sharer_directory (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type), .req_core(req_core),
    .req_blk(req_blk), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_core(rsp_core),
    .rsp_blk(rsp_blk), .rsp_data(rsp_data),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_kind(fwd_kind), .fwd_core(fwd_core),
    .fwd_req_core(fwd_req_core), .fwd_blk(fwd_blk),
    .own_valid(own_valid), .own_data(own_data),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_mask(inv_mask), .inv_blk(inv_blk),
    .ack_valid(ack_valid), .ack_core(ack_core),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_blk(mem_req_blk),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int nchk = 0, nerr = 0;
  bit finished = 0;

  // reference state: 0 uncached, 1 shared, 2 owned
  int            m_st [NE];
  logic [NC-1:0] m_sh [NE];
  logic [DW-1:0] m_dat[NE];
  bit            m_pr [NE];
  logic [DW-1:0] last_own;
  int            own_cnt = 0;

  // observations of one transaction
  bit            o_mem, o_fwd, o_inv, o_early, o_moved;
  logic [2:0]    o_memblk;
  logic [1:0]    o_fwdc, o_fwdrq, o_kind, o_core;
  logic          o_fwdk;
  logic [NC-1:0] o_invm;
  logic [DW-1:0] o_data;

  function automatic logic [DW-1:0] memval(int b);
    return 32'hA000_0000 + 32'(b) * 32'h111;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(logic [1:0] t, int c, int b, logic [DW-1:0] d);
    int mem_cd = -1, own_cd = -1, ack_cd = -1, stall = 0, guard = 0;
    logic [NC-1:0] ack_left = '0;
    logic [DW-1:0] held = '0;
    bit done = 0;
    o_mem = 0; o_fwd = 0; o_inv = 0; o_early = 0; o_moved = 0; o_invm = '0;
    @(negedge clk);
    req_valid = 1; req_type = t; req_core = 2'(c); req_blk = 3'(b); req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R10 ready low while busy", {31'd0, req_ready}, 0);
    while (!done && guard < 300) begin
      guard++;
      mem_rsp_valid = 0; own_valid = 0; ack_valid = 0; rsp_ready = 0;
      if (mem_cd == 0) begin mem_rsp_valid = 1; mem_rsp_data = memval(b); end
      if (mem_cd >= 0) mem_cd--;
      if (own_cd == 0) begin
        own_valid = 1; last_own = 32'hC0DE_0000 + 32'(own_cnt); own_data = last_own; own_cnt++;
      end
      if (own_cd >= 0) own_cd--;
      if (ack_left != '0) begin
        if (ack_cd <= 0) begin
          for (int k = 0; k < NC; k++)
            if (ack_left[k] && !ack_valid) begin
              ack_valid = 1; ack_core = 2'(k); ack_left[k] = 1'b0;
            end
        end else ack_cd--;
      end
      if (mem_req_valid) begin o_mem = 1; o_memblk = mem_req_blk; mem_cd = 2; end
      if (fwd_valid) begin
        o_fwd = 1; o_fwdc = fwd_core; o_fwdk = fwd_kind; o_fwdrq = fwd_req_core; own_cd = 2;
      end
      if (inv_valid) begin o_inv = 1; o_invm = inv_mask; ack_left = inv_mask; ack_cd = 2; end
      if (rsp_valid) begin
        if (ack_left != '0) o_early = 1;
        if (stall == 0) held = rsp_data;
        else if (rsp_data !== held) o_moved = 1;
        if (stall < 2) stall++;
        else begin
          rsp_ready = 1; done = 1;
          o_kind = rsp_kind; o_data = rsp_data; o_core = rsp_core;
        end
      end
      @(negedge clk);
    end
    rsp_ready = 0; mem_rsp_valid = 0; own_valid = 0; ack_valid = 0;
    if (!done) chk("R10 transaction never completed", 0, 1);
  endtask

  task automatic run_and_check(logic [1:0] t, int c, int b, logic [DW-1:0] d);
    bit e_mem = 0, e_fwd = 0; logic [1:0] e_fwdc = 0; logic e_fwdk = 0;
    logic [NC-1:0] e_inv = '0, bit_c; logic [1:0] e_kind; logic [DW-1:0] e_data;
    string tag;
    bit_c = 4'b1 << c;
    xact(t, c, b, d);
    if (t == 2'd3) begin
      tag = "R9";
      if (m_st[b] == 2 && m_sh[b] == bit_c) begin m_dat[b] = d; m_st[b] = 0; m_sh[b] = '0; end
      e_kind = 2; e_data = 0;
    end else begin
      if (!m_pr[b]) begin e_mem = 1; m_pr[b] = 1; m_dat[b] = memval(b); end
      if (m_st[b] == 0) begin
        tag = (t == 2'd2) ? "R4" : (t == 2'd1) ? "R7" : "R3";
        m_st[b] = (t == 2'd2) ? 1 : 2; m_sh[b] = bit_c; e_kind = (t == 2'd2) ? 0 : 1;
      end else if (m_st[b] == 1) begin
        if (t == 2'd1) begin
          e_inv = m_sh[b] & ~bit_c; tag = (e_inv != 0) ? "R6" : "R7";
          m_st[b] = 2; m_sh[b] = bit_c; e_kind = 1;
        end else begin
          tag = "R5"; m_sh[b] |= bit_c; e_kind = 0;
        end
      end else if (m_sh[b] == bit_c) begin
        tag = "R3"; e_kind = 1;
      end else begin
        tag = "R8"; e_fwd = 1; e_fwdk = (t == 2'd1);
        for (int k = 0; k < NC; k++) if (m_sh[b][k]) e_fwdc = 2'(k);
        m_dat[b] = last_own;
        if (t == 2'd1) begin m_sh[b] = bit_c; e_kind = 1; end
        else begin m_st[b] = 1; m_sh[b] |= bit_c; e_kind = 0; end
      end
      e_data = m_dat[b];
    end
    chk({tag, " response kind"}, {30'd0, o_kind}, {30'd0, e_kind});
    chk({tag, " response data"}, o_data, e_data);
    chk({tag, " response core"}, {30'd0, o_core}, 32'(c));
    chk("R2 memory fetch issued", {31'd0, o_mem}, {31'd0, e_mem});
    if (e_mem) chk("R2 memory fetch block", {29'd0, o_memblk}, 32'(b));
    chk("R8 forward issued", {31'd0, o_fwd}, {31'd0, e_fwd});
    if (e_fwd && o_fwd) begin
      chk("R8 forward owner", {30'd0, o_fwdc}, {30'd0, e_fwdc});
      chk("R8 forward kind", {31'd0, o_fwdk}, {31'd0, e_fwdk});
      chk("R8 forward requester", {30'd0, o_fwdrq}, 32'(c));
    end
    chk("R6 invalidation mask", {28'd0, o_invm}, {28'd0, e_inv});
    chk("R6 grant before all acks", {31'd0, o_early}, 0);
    chk("R11 response held while stalled", {31'd0, o_moved}, 0);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) begin m_st[i] = 0; m_sh[i] = '0; m_pr[i] = 0; m_dat[i] = '0; end
    last_own = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", {31'd0, req_ready}, 1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R1 fwd_valid", {31'd0, fwd_valid}, 0);
    chk("R1 inv_valid", {31'd0, inv_valid}, 0);
    chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 0);
    // directed: R2 R3 R8 R5 R6 R9 R4 R7
    run_and_check(2'd0, 0, 0, 0);
    run_and_check(2'd0, 1, 0, 0);
    run_and_check(2'd2, 2, 0, 0);
    run_and_check(2'd1, 3, 0, 0);
    run_and_check(2'd3, 1, 0, 32'hDEAD_0001);
    run_and_check(2'd3, 3, 0, 32'hBEEF_0003);
    run_and_check(2'd0, 0, 0, 0);
    run_and_check(2'd2, 1, 1, 0);
    run_and_check(2'd1, 1, 1, 0);
    run_and_check(2'd1, 2, 1, 0);
    // sweep over every block, core and request type
    for (int b = 0; b < NE; b++)
      for (int i = 0; i < 16; i++)
        run_and_check(2'((i * 3 + b + i / 4) % 4), (i * 7 + b * 3 + i / 4) % 4, b,
                      32'h5000_0000 + 32'(b * 256 + i));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule